// File: doc/BRIEF.md
# Line-Doubling Scan Converter

This block turns a low-rate raster into one at twice the line rate. It stores each incoming scanline of 4-bit colour pixels, then sends that line out twice while the next input line is being stored. As a result, every input line period holds two output lines. A source at roughly 15.75 kHz line rate becomes a roughly 31.5 kHz stream, and the output is only about one input line behind the input.

The block runs on a single clock. An input pixel is offered with a strobe, and a one-cycle pulse marks the first cycle of each input line. The block measures the number of cycles between two line-start pulses and uses half of that count as the output line period. Two line stores take turns: while one is written, the other is read. Each pixel is 4 bits wide, with bit 3 = red, bit 2 = green, bit 1 = blue and bit 0 = intensity. In this encoding yellow is 4'b1101 and blue is 4'b0010.

For low-resolution colour sources there is an optional scanline effect. It blanks the repeated copy of each line and leaves the first copy untouched.

Top module: `line_doubler`

## Requirements
- R1: After reset, and until the first output pixel is due, `vld_o`, `odd_o` and `pix_o` are all 0.
- R2: Take a line-start pulse sampled on clock edge k. The line that this pulse closes is played out with its first pixel on `pix_o` after edge k+2, followed by one pixel per cycle.
- R3: Each output copy lasts H = floor(P/2) cycles, where P is the number of cycles between the closing line-start pulse and the one before it. The second copy starts H cycles after the first. `odd_o` is 1 for the whole second copy and 0 otherwise. If P is odd, there is one idle cycle after the second copy.
- R4: Within a copy, positions at or beyond the stored pixel count, and idle cycles, output `vld_o`=0 and `pix_o`=4'b0000.
- R5: When `scan_en_i`=1 and `lowres_i`=1, the second copy shows `pix_o`=4'b0000 while `vld_o` stays 1. The first copy is unchanged.
- R6: When `lowres_i`=0, `scan_en_i` has no effect on either copy.
- R7: If a line has more than LINE_MAX pixels, only the first LINE_MAX are stored and played. The rest are dropped.
- R8: Nothing is captured for output before the first line-start pulse, so no output is valid during the first line after reset.
- R9: The two line stores alternate on each line start. A line being written never changes the line being played.
- R10: A pixel strobed in the same cycle as the line-start pulse is pixel 0 of the new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_vld_i | input | 1 | Input pixel strobe |
| pix_i | input | 4 | Input pixel, {R,G,B,I} |
| line_start_i | input | 1 | One-cycle pulse on the first cycle of an input line |
| scan_en_i | input | 1 | Scanline effect enable |
| lowres_i | input | 1 | Source is a low-resolution colour mode |
| pix_o | output | 4 | Output pixel, {R,G,B,I} |
| vld_o | output | 1 | Output pixel valid |
| odd_o | output | 1 | 1 while the repeated copy of a line is being played |

## Verification
Several properties are checked on every cycle:
- the write count never passes the line store depth;
- the first line after reset never starts a playback;
- each line swap restarts playback at position 0 of the first copy;
- outside the swap cycle, the read store is never the store being written;
- the blanked second copy always outputs zero.

Other behaviour can only be shown by the bench's scenarios, because the bench compares the output against a model of the previous line's data:
- the exact playback latency and copy length for even and odd line periods;
- the pixel order;
- dropping of pixels after the store fills;
- gating of the scanline effect by the low-resolution flag.

// File: rtl/ld_pkg.sv
package ld_pkg;
  localparam int unsigned RGBI_W = 4;
  typedef logic [RGBI_W-1:0] rgbi_t;
  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/ld_capture.sv
module ld_capture
  import ld_pkg::*;
#(
  parameter int unsigned LINE_MAX = 64,
  parameter int unsigned PER_W    = 12,
  localparam int unsigned AW = $clog2(LINE_MAX),
  localparam int unsigned LW = $clog2(LINE_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_vld_i,
  input  rgbi_t            pix_i,
  input  logic             line_start_i,
  output logic             wr_en_o,
  output logic             wr_bank_o,
  output logic [AW-1:0]    wr_addr_o,
  output rgbi_t            wr_data_o,
  output logic             cur_bank_o,
  output logic             swap_o,
  output logic [LW-1:0]    len_o,
  output logic [PER_W-1:0] per_o,
  output logic             bank_o
);
  logic             wr_bank;
  logic [LW-1:0]    wr_cnt;
  logic [PER_W-1:0] cyc_cnt;
  logic             started;
  logic             room;

  always_comb begin
    room      = wr_cnt < LW'(LINE_MAX);
    wr_en_o   = pix_vld_i && (line_start_i || room);
    wr_addr_o = line_start_i ? '0 : wr_cnt[AW-1:0];
    wr_bank_o = line_start_i ? ~wr_bank : wr_bank;
    wr_data_o = pix_i;
  end

  assign cur_bank_o = wr_bank;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_bank <= 1'b0;
      wr_cnt  <= '0;
      cyc_cnt <= '0;
      started <= 1'b0;
      swap_o  <= 1'b0;
      len_o   <= '0;
      per_o   <= '0;
      bank_o  <= 1'b0;
    end else if (line_start_i) begin
      wr_bank <= ~wr_bank;
      wr_cnt  <= pix_vld_i ? LW'(1) : '0;
      cyc_cnt <= '0;
      started <= 1'b1;
      swap_o  <= started;           // first line after reset is not played
      len_o   <= wr_cnt;
      per_o   <= (&cyc_cnt) ? cyc_cnt : cyc_cnt + 1'b1;
      bank_o  <= wr_bank;
    end else begin
      swap_o <= 1'b0;
      if (wr_en_o) wr_cnt <= wr_cnt + 1'b1;
      if (!(&cyc_cnt)) cyc_cnt <= cyc_cnt + 1'b1;
    end
  end

  // R7: write count saturates at the store depth
  p_cnt_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt <= LW'(LINE_MAX));

  // R8: the first line start after reset never launches playback
  p_first_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(started) |-> !swap_o);
endmodule

// File: rtl/ld_linebuf.sv
module ld_linebuf
  import ld_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          wbank_i,
  input  logic [AW-1:0] waddr_i,
  input  rgbi_t         wdata_i,
  input  logic          rbank_i,
  input  logic [AW-1:0] raddr_i,
  output rgbi_t         rdata_o
);
  rgbi_t bank_rd [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    rgbi_t mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && (wbank_i == g[0])) mem[waddr_i] <= wdata_i;
    end
    assign bank_rd[g] = mem[raddr_i];
  end

  assign rdata_o = bank_rd[rbank_i];
endmodule

// File: rtl/ld_playback.sv
module ld_playback
  import ld_pkg::*;
#(
  parameter int unsigned PER_W = 12,
  parameter int unsigned LW    = 7,
  parameter int unsigned AW    = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             swap_i,
  input  logic [LW-1:0]    len_i,
  input  logic [PER_W-1:0] per_i,
  input  logic             bank_i,
  input  logic             wr_bank_i,
  input  rgbi_t            rd_data_i,
  input  logic             scan_en_i,
  input  logic             lowres_i,
  output logic             rd_bank_o,
  output logic [AW-1:0]    rd_addr_o,
  output rgbi_t            pix_o,
  output logic             vld_o,
  output logic             odd_o
);
  logic             act;
  logic             copy;
  logic [PER_W-1:0] pos;
  logic [PER_W-1:0] half;
  logic [LW-1:0]    len;
  logic [PER_W-1:0] half_in;
  logic             in_len;
  logic             dim;

  always_comb begin
    half_in = per_i >> 1;
    if (half_in == '0) half_in = PER_W'(1);
    in_len = act && (pos < PER_W'(len));
    dim    = copy && scan_en_i && lowres_i;
  end

  assign rd_addr_o = pos[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act       <= 1'b0;
      copy      <= 1'b0;
      pos       <= '0;
      half      <= PER_W'(1);
      len       <= '0;
      rd_bank_o <= 1'b0;
    end else if (swap_i) begin
      act       <= 1'b1;
      copy      <= 1'b0;
      pos       <= '0;
      half      <= half_in;
      len       <= len_i;
      rd_bank_o <= bank_i;
    end else if (act) begin
      if (pos == half - 1'b1) begin
        pos <= '0;
        if (copy) begin
          act  <= 1'b0;
          copy <= 1'b0;
        end else begin
          copy <= 1'b1;
        end
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o <= '0;
      vld_o <= 1'b0;
      odd_o <= 1'b0;
    end else begin
      vld_o <= in_len;
      odd_o <= act && copy;
      pix_o <= (in_len && !dim) ? rd_data_i : '0;
    end
  end

  // R2: each swap restarts playback at the head of the first copy
  p_swap_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i |=> (act && !copy && pos == '0));

  // R5: blanked repeat copy drives zero pixels
  p_dim_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && copy && scan_en_i && lowres_i) |=> (pix_o == '0));

  // R9: the store being read is never the one being written
  p_pingpong_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && !swap_i) |-> (rd_bank_o != wr_bank_i));
endmodule

// File: rtl/line_doubler.sv
module line_doubler
  import ld_pkg::*;
#(
  parameter int unsigned LINE_MAX = 64,
  parameter int unsigned PER_W    = 12,
  localparam int unsigned AW = $clog2(LINE_MAX),
  localparam int unsigned LW = $clog2(LINE_MAX + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pix_vld_i,
  input  logic [3:0] pix_i,
  input  logic       line_start_i,
  input  logic       scan_en_i,
  input  logic       lowres_i,
  output logic [3:0] pix_o,
  output logic       vld_o,
  output logic       odd_o
);
  logic             wr_en;
  logic             wr_bank;
  logic [AW-1:0]    wr_addr;
  rgbi_t            wr_data;
  logic             cur_bank;
  logic             swap;
  logic [LW-1:0]    len;
  logic [PER_W-1:0] per;
  logic             done_bank;
  logic             rd_bank;
  logic [AW-1:0]    rd_addr;
  rgbi_t            rd_data;

  ld_capture #(.LINE_MAX(LINE_MAX), .PER_W(PER_W)) u_capture (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pix_vld_i    (pix_vld_i),
    .pix_i        (pix_i),
    .line_start_i (line_start_i),
    .wr_en_o      (wr_en),
    .wr_bank_o    (wr_bank),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data),
    .cur_bank_o   (cur_bank),
    .swap_o       (swap),
    .len_o        (len),
    .per_o        (per),
    .bank_o       (done_bank)
  );

  ld_linebuf #(.DEPTH(LINE_MAX)) u_linebuf (
    .clk_i   (clk_i),
    .we_i    (wr_en),
    .wbank_i (wr_bank),
    .waddr_i (wr_addr),
    .wdata_i (wr_data),
    .rbank_i (rd_bank),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  ld_playback #(.PER_W(PER_W), .LW(LW), .AW(AW)) u_playback (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .swap_i    (swap),
    .len_i     (len),
    .per_i     (per),
    .bank_i    (done_bank),
    .wr_bank_i (cur_bank),
    .rd_data_i (rd_data),
    .scan_en_i (scan_en_i),
    .lowres_i  (lowres_i),
    .rd_bank_o (rd_bank),
    .rd_addr_o (rd_addr),
    .pix_o     (pix_o),
    .vld_o     (vld_o),
    .odd_o     (odd_o)
  );
endmodule

// File: tb/line_doubler_bench.sv
module line_doubler_bench;
  localparam int LMAX = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_vld = 1'b0;
  logic [3:0] pix = '0;
  logic       line_start = 1'b0;
  logic       scan_en = 1'b0;
  logic       lowres = 1'b0;
  logic [3:0] pix_o;
  logic       vld_o;
  logic       odd_o;

  int checks = 0;
  int errors = 0;

  logic [3:0] prev_d [128];
  logic [3:0] cur_d  [128];
  int prev_len = 0;
  int prev_per = 0;
  bit prev_ok  = 1'b0;

  always #10 clk = ~clk;

  line_doubler #(.LINE_MAX(LMAX)) u_line_doubler (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .pix_vld_i    (pix_vld),
    .pix_i        (pix),
    .line_start_i (line_start),
    .scan_en_i    (scan_en),
    .lowres_i     (lowres),
    .pix_o        (pix_o),
    .vld_o        (vld_o),
    .odd_o        (odd_o)
  );

  task automatic check(input string req, input int c, input logic ev, input logic eo,
                       input logic [3:0] ep);
    checks++;
    if (vld_o !== ev || odd_o !== eo || pix_o !== ep) begin
      errors++;
      $display("FAIL %s c=%0d: vld=%0b exp %0b, odd=%0b exp %0b, pix=%h exp %h",
               req, c, vld_o, ev, odd_o, eo, pix_o, ep);
    end
  endtask

  // Drives one input line of per cycles with len pixels (one every two cycles,
  // pixel 0 in the line-start cycle) and checks the playback of the previous line.
  task automatic run_line(input int len, input int per, input int seed,
                          input bit scan, input bit lr, input string req);
    int half;
    scan_en = scan;
    lowres  = lr;
    for (int j = 0; j < 128; j++) cur_d[j] = 4'((seed + j * 5 + (j >> 2)) & 15);
    half = prev_per / 2;
    if (half < 1) half = 1;
    for (int c = 0; c < per; c++) begin
      line_start = (c == 0);
      pix_vld    = (c % 2 == 0) && (c / 2 < len);
      pix        = pix_vld ? cur_d[c / 2] : 4'h0;
      @(negedge clk);
      if (c >= 2) begin
        int idx;
        bit cp;
        int j;
        logic ev;
        logic [3:0] ep;
        idx = c - 2;
        if (!prev_ok || idx >= 2 * half) begin
          check(req, c, 1'b0, 1'b0, 4'h0);
        end else begin
          cp = (idx >= half);
          j  = cp ? idx - half : idx;
          ev = (j < prev_len);
          ep = ev ? ((cp && scan && lr) ? 4'h0 : prev_d[j]) : 4'h0;
          check(req, c, ev, cp, ep);
        end
      end
    end
    line_start = 1'b0;
    pix_vld    = 1'b0;
    for (int j = 0; j < 128; j++) prev_d[j] = cur_d[j];
    prev_len = (len > LMAX) ? LMAX : len;
    prev_per = per;
    prev_ok  = 1'b1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", 0, 1'b0, 1'b0, 4'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", 1, 1'b0, 1'b0, 4'h0);
  endtask

  task automatic t_first_line;
    run_line(10, 40, 3, 1'b0, 1'b0, "R8");
  endtask

  task automatic t_basic;
    run_line(16, 40, 7, 1'b0, 1'b0, "R2/R3/R4/R10");
    run_line(12, 36, 11, 1'b0, 1'b0, "R2/R3/R4/R10");
  endtask

  task automatic t_odd_period;
    run_line(8, 31, 2, 1'b0, 1'b0, "R3");
    run_line(9, 27, 9, 1'b0, 1'b0, "R3/R4");
  endtask

  task automatic t_scanline;
    run_line(14, 40, 5, 1'b1, 1'b1, "R5");
    run_line(14, 40, 13, 1'b1, 1'b1, "R5");
  endtask

  task automatic t_lowres_gate;
    run_line(14, 40, 1, 1'b1, 1'b0, "R6");
    run_line(10, 40, 4, 1'b1, 1'b0, "R6");
  endtask

  task automatic t_overflow;
    run_line(70, 150, 6, 1'b0, 1'b0, "R7");
    run_line(5, 150, 8, 1'b0, 1'b0, "R7");
  endtask

  task automatic t_pingpong;
    for (int n = 0; n < 4; n++) run_line(20, 44, 20 + n * 3, 1'b0, 1'b0, "R9");
    run_line(4, 44, 0, 1'b0, 1'b0, "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_first_line();
    t_basic();
    t_odd_period();
    t_scanline();
    t_lowres_gate();
    t_overflow();
    t_pingpong();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule